// File: doc/BRIEF.md
# In-Lane Double-Precision Permute Unit

This execution unit rearranges 64-bit elements of a 256-bit source vector. An element never leaves its 128-bit lane. Each result element picks either the lower or the upper element of its own lane. The unit moves bits only and performs no floating-point arithmetic.

The per-element selects come from one of two places:
- **Immediate form:** an 8-bit immediate, one bit per result element.
- **Variable form:** bit 1 of each 64-bit element of a second control vector.

Each form runs at 256-bit or 128-bit width. The 128-bit width clears the upper half of the result.

The unit also checks two decode fields and raises an undefined-opcode fault on an illegal combination:
- a single W bit;
- a 4-bit spare register-specifier field.

The unit has one register stage. An accepted operation gives a result and a valid pulse one clock later. A faulting operation gives a one-cycle fault pulse in the same slot, with no result.

Top module: `lanePermuteUnit`

## Requirements
- R1: Result elements 0 and 1 take their data only from source elements 0 or 1. Result elements 2 and 3 take theirs only from source elements 2 or 3. A select of 0 picks the lower element of the lane, and a select of 1 picks the upper one.
- R2: With `immForm`=1, result element i is selected by `immCtl[i]`. Immediate bits 7:4 have no effect on the result.
- R3: With `immForm`=0, result element i is selected by `ctrlVec` bit 64*i+1, that is, bit 1, 65, 129 or 193. Every other control-vector bit has no effect.
- R4: With `wideMode`=0, result bits 255:128 are zero. At this width, immediate bits 3:2 and control-vector elements 2 and 3 have no effect.
- R5: An accepted operation presented with `inValid`=1 at a clock edge shows its result on `resVec` with `resValid`=1 after exactly that edge. `resValid` stays high for one cycle per operation.
- R6: `wBit`=1 with `inValid`=1 raises the fault in all four forms.
- R7: In the immediate form, an `extraReg` value other than 4'b1111 raises the fault. In the variable form, `extraReg` has no effect.
- R8: For a faulting operation, `udFault` pulses high for one cycle in the slot where `resValid` would have risen. `resValid` stays low, and `resVec` keeps its previous value.
- R9: A synchronous active-high `rst` clears `resValid`, `udFault` and `resVec` to zero.
- R10: A cycle with `inValid`=0 leaves `resVec` unchanged and gives `resValid`=0 and `udFault`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operation present this cycle |
| srcVec | input | 256 | Source elements, element i at bits 64*i+63:64*i |
| ctrlVec | input | 256 | Variable-form control vector |
| immCtl | input | 8 | Immediate-form select byte |
| wideMode | input | 1 | 1 = 256-bit width, 0 = 128-bit width |
| immForm | input | 1 | 1 = selects from immediate, 0 = selects from control vector |
| wBit | input | 1 | Decode W bit, 1 is illegal |
| extraReg | input | 4 | Spare register-specifier field, must be 4'b1111 in immediate form |
| resVec | output | 256 | Registered permuted result |
| resValid | output | 1 | Result valid pulse |
| udFault | output | 1 | Undefined-opcode fault pulse |

## Verification
Three outputs are due one clock edge after the stimulus that produced them:
- `resVec` and `resValid` after an accepted operation;
- `udFault` after a faulting operation.

An unchanged `resVec` is also due at that edge after a fault or an idle cycle.

Inputs are driven on the falling edge. The bench's behavioural model updates its expected state on the rising edge that captures those inputs. All three outputs are compared against that expected state on the next falling edge. A result that comes early, comes late, or is missing therefore shows up as a mismatch in a specific cycle.

// File: rtl/lanePermutePkg.sv
package lanePermutePkg;

  // Strobes passed from the decode/control half to the datapath half
  typedef struct packed {
    logic capture;     // legal operation: load result, raise valid
    logic faultPulse;  // illegal operation: raise fault, hold result
    logic narrow;      // 128-bit width: clear the upper lane(s)
  } permStrobe_t;

  localparam int IMM_W   = 8;
  localparam int XREG_W  = 4;

endpackage

// File: rtl/lanePermuteCtrl.sv
module lanePermuteCtrl
  import lanePermutePkg::*;
#(
  parameter int ELEM_W    = 64,
  parameter int NUM_ELEMS = 4,
  parameter int SEL_BIT   = 1,
  localparam int VEC_W    = ELEM_W * NUM_ELEMS
) (
  input  logic                  inValid,
  input  logic [VEC_W-1:0]      ctrlVec,
  input  logic [IMM_W-1:0]      immCtl,
  input  logic                  wideMode,
  input  logic                  immForm,
  input  logic                  wBit,
  input  logic [XREG_W-1:0]     extraReg,
  output permStrobe_t           strb,
  output logic [NUM_ELEMS-1:0]  sel
);

  logic illegalOp;
  logic xregBad;
  logic ctrlUnused;
  logic immUnused;

  assign xregBad   = immForm && (extraReg != {XREG_W{1'b1}});
  assign illegalOp = wBit || xregBad;

  assign strb.capture    = inValid && !illegalOp;
  assign strb.faultPulse = inValid && illegalOp;
  assign strb.narrow     = !wideMode;

  // Per-element select: immediate bit or one bit of the control element
  for (genvar e = 0; e < NUM_ELEMS; e++) begin : g_sel
    assign sel[e] = immForm ? immCtl[e] : ctrlVec[e*ELEM_W + SEL_BIT];
  end

  // The remaining control bits carry no meaning for this unit
  assign ctrlUnused = ^ctrlVec;
  assign immUnused  = ^immCtl;

endmodule

// File: rtl/lanePermuteDatapath.sv
module lanePermuteDatapath
  import lanePermutePkg::*;
#(
  parameter int ELEM_W       = 64,
  parameter int NUM_ELEMS    = 4,
  parameter int NARROW_ELEMS = 2,
  localparam int VEC_W       = ELEM_W * NUM_ELEMS,
  localparam int LANE_ELEMS  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  permStrobe_t           strb,
  input  logic [NUM_ELEMS-1:0]  sel,
  input  logic [VEC_W-1:0]      srcVec,
  output logic [VEC_W-1:0]      resVec,
  output logic                  resValid,
  output logic                  udFault
);

  logic [VEC_W-1:0] nextVec;

  for (genvar e = 0; e < NUM_ELEMS; e++) begin : g_elem
    localparam int LANE_BASE = (e / LANE_ELEMS) * LANE_ELEMS;
    logic [ELEM_W-1:0] picked;
    assign picked = sel[e] ? srcVec[(LANE_BASE+1)*ELEM_W +: ELEM_W]
                           : srcVec[LANE_BASE*ELEM_W +: ELEM_W];
    if (e < NARROW_ELEMS) begin : g_low
      assign nextVec[e*ELEM_W +: ELEM_W] = picked;
    end else begin : g_high
      assign nextVec[e*ELEM_W +: ELEM_W] = strb.narrow ? '0 : picked;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resVec   <= '0;
      resValid <= 1'b0;
      udFault  <= 1'b0;
    end else begin
      resValid <= strb.capture;
      udFault  <= strb.faultPulse;
      if (strb.capture) resVec <= nextVec;
    end
  end

endmodule

// File: rtl/lanePermuteUnit.sv
module lanePermuteUnit
  import lanePermutePkg::*;
#(
  parameter int ELEM_W       = 64,
  parameter int NUM_ELEMS    = 4,
  parameter int NARROW_ELEMS = 2,
  parameter int SEL_BIT      = 1,
  localparam int VEC_W       = ELEM_W * NUM_ELEMS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [VEC_W-1:0]   srcVec,
  input  logic [VEC_W-1:0]   ctrlVec,
  input  logic [IMM_W-1:0]   immCtl,
  input  logic               wideMode,
  input  logic               immForm,
  input  logic               wBit,
  input  logic [XREG_W-1:0]  extraReg,
  output logic [VEC_W-1:0]   resVec,
  output logic               resValid,
  output logic               udFault
);

  permStrobe_t          strb;
  logic [NUM_ELEMS-1:0] sel;

  lanePermuteCtrl #(
    .ELEM_W(ELEM_W), .NUM_ELEMS(NUM_ELEMS), .SEL_BIT(SEL_BIT)
  ) uCtrl (
    .inValid(inValid), .ctrlVec(ctrlVec), .immCtl(immCtl),
    .wideMode(wideMode), .immForm(immForm), .wBit(wBit),
    .extraReg(extraReg), .strb(strb), .sel(sel)
  );

  lanePermuteDatapath #(
    .ELEM_W(ELEM_W), .NUM_ELEMS(NUM_ELEMS), .NARROW_ELEMS(NARROW_ELEMS)
  ) uPath (
    .clk(clk), .rst(rst), .strb(strb), .sel(sel), .srcVec(srcVec),
    .resVec(resVec), .resValid(resValid), .udFault(udFault)
  );

endmodule

// File: rtl/lanePermuteChecker.sv
module lanePermuteChecker #(
  parameter int VEC_W = 256
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic [VEC_W-1:0] srcVec,
  input logic [7:0]       immCtl,
  input logic             wideMode,
  input logic             immForm,
  input logic             wBit,
  input logic [3:0]       extraReg,
  input logic [VEC_W-1:0] resVec,
  input logic             resValid,
  input logic             udFault
);

  // R5: a valid result always traces back to an input strobe one edge earlier
  assert_valid_follows_input_R5: assert property (@(posedge clk) disable iff (rst)
    resValid |-> $past(inValid));

  // R8: result and fault never share a slot
  assert_fault_excludes_valid_R8: assert property (@(posedge clk) disable iff (rst)
    !(resValid && udFault));

  // R8: fault holds the result register
  assert_fault_holds_result_R8: assert property (@(posedge clk) disable iff (rst)
    udFault |-> $stable(resVec));

  // R6: W bit set on a valid op produces the fault next cycle
  assert_wbit_faults_R6: assert property (@(posedge clk) disable iff (rst)
    (inValid && wBit) |=> udFault);

  // R7: bad spare field in immediate form faults
  assert_xreg_faults_R7: assert property (@(posedge clk) disable iff (rst)
    (inValid && immForm && extraReg != 4'hF) |=> udFault);

  // R10: idle cycle holds the result
  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(resVec) && !resValid && !udFault));

  // R4: narrow width leaves the upper half clear
  assert_narrow_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (inValid && !wideMode && !wBit && !(immForm && extraReg != 4'hF))
      |=> (resVec[VEC_W-1:VEC_W/2] == '0));

  // R1: lowest result element comes from lane 0 as chosen by immediate bit 0
  assert_elem0_in_lane_R1: assert property (@(posedge clk) disable iff (rst)
    (inValid && immForm && !wBit && extraReg == 4'hF)
      |=> (resVec[63:0] == ($past(immCtl[0]) ? $past(srcVec[127:64])
                                              : $past(srcVec[63:0]))));

endmodule

bind lanePermuteUnit lanePermuteChecker #(.VEC_W(VEC_W)) uChk (
  .clk(clk), .rst(rst), .inValid(inValid), .srcVec(srcVec), .immCtl(immCtl),
  .wideMode(wideMode), .immForm(immForm), .wBit(wBit), .extraReg(extraReg),
  .resVec(resVec), .resValid(resValid), .udFault(udFault)
);

// File: tb/sim_lanePermuteUnit.sv
`timescale 1ns/1ps
module sim_lanePermuteUnit;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [255:0] srcVec = '0;
  logic [255:0] ctrlVec = '0;
  logic [7:0]   immCtl = '0;
  logic         wideMode = 1'b1;
  logic         immForm = 1'b1;
  logic         wBit = 1'b0;
  logic [3:0]   extraReg = 4'hF;
  logic [255:0] resVec;
  logic         resValid;
  logic         udFault;

  int total = 0;
  int bad = 0;
  bit started = 0;
  bit done = 0;

  // Reference model state
  logic [255:0] expVec = '0;
  logic         expValid = 1'b0;
  logic         expFault = 1'b0;
  string        expTag = "R9";

  always #4 clk = ~clk;

  lanePermuteUnit u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .srcVec(srcVec),
    .ctrlVec(ctrlVec), .immCtl(immCtl), .wideMode(wideMode),
    .immForm(immForm), .wBit(wBit), .extraReg(extraReg),
    .resVec(resVec), .resValid(resValid), .udFault(udFault)
  );

  function automatic logic [255:0] modelPermute(
      input logic [255:0] s, input logic [255:0] c, input logic [7:0] im,
      input logic wide, input logic immf);
    logic [255:0] o;
    o = '0;
    for (int e = 0; e < 4; e++) begin
      int lane;
      int pick;
      lane = e / 2;
      pick = immf ? int'(im[e]) : int'(c[e*64 + 1]);
      if (wide || e < 2) o[e*64 +: 64] = s[(lane*2 + pick)*64 +: 64];
    end
    return o;
  endfunction

  function automatic logic [255:0] rand256();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  // Behavioural model advanced on each capturing edge
  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      expVec <= '0; expValid <= 1'b0; expFault <= 1'b0; expTag <= "R9";
    end else if (!inValid) begin
      expValid <= 1'b0; expFault <= 1'b0; expTag <= "R10";
    end else if (wBit || (immForm && extraReg != 4'hF)) begin
      expValid <= 1'b0; expFault <= 1'b1;
      expTag <= wBit ? "R6/R8" : "R7/R8";
    end else begin
      expVec   <= modelPermute(srcVec, ctrlVec, immCtl, wideMode, immForm);
      expValid <= 1'b1; expFault <= 1'b0;
      expTag   <= !wideMode ? "R4/R5" : (immForm ? "R1/R2/R5" : "R1/R3/R5");
    end
  end

  // Compare every cycle, away from the capturing edge
  always @(negedge clk) begin
    if (started && !done) begin
      total++;
      if (resVec !== expVec || resValid !== expValid || udFault !== expFault) begin
        bad++;
        $display("FAIL %s: got vec=%h v=%b f=%b exp vec=%h v=%b f=%b",
                 expTag, resVec, resValid, udFault, expVec, expValid, expFault);
      end
    end
  end

  task automatic drive(input logic v, input logic [255:0] s, input logic [255:0] c,
                       input logic [7:0] im, input logic wide, input logic immf,
                       input logic w, input logic [3:0] xr);
    @(negedge clk);
    inValid = v; srcVec = s; ctrlVec = c; immCtl = im;
    wideMode = wide; immForm = immf; wBit = w; extraReg = xr;
  endtask

  task automatic idle();
    drive(1'b0, rand256(), rand256(), 8'($urandom), 1'b1, 1'b1, 1'b0, 4'hF);
  endtask

  task automatic finishRun();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state, observed directly
    total++;
    if (resVec !== '0 || resValid !== 1'b0 || udFault !== 1'b0) begin
      bad++;
      $display("FAIL R9: got vec=%h v=%b f=%b exp all zero", resVec, resValid, udFault);
    end
    rst = 1'b0;

    // R1 R2: every immediate value at 256-bit width, bits 7:4 included
    for (int im = 0; im < 256; im++)
      drive(1'b1, rand256(), rand256(), 8'(im), 1'b1, 1'b1, 1'b0, 4'hF);
    // R4: every immediate value at 128-bit width
    for (int im = 0; im < 256; im++)
      drive(1'b1, rand256(), rand256(), 8'(im), 1'b0, 1'b1, 1'b0, 4'hF);
    idle();

    // R3 R4: all select patterns through bits 1/65/129/193, random other bits
    for (int rep = 0; rep < 8; rep++) begin
      for (int p = 0; p < 16; p++) begin
        logic [255:0] c;
        c = rand256();
        for (int e = 0; e < 4; e++) c[e*64 + 1] = p[e];
        drive(1'b1, rand256(), c, 8'($urandom), rep[0], 1'b0, 1'b0, 4'($urandom));
      end
      idle();
    end

    // R6 R8: W bit in each of the four forms
    for (int f = 0; f < 4; f++) begin
      drive(1'b1, rand256(), rand256(), 8'($urandom), f[0], f[1], 1'b1, 4'hF);
      idle();
    end

    // R7: every spare-field value in immediate and variable form
    for (int xr = 0; xr < 16; xr++) begin
      drive(1'b1, rand256(), rand256(), 8'($urandom), 1'b1, 1'b1, 1'b0, 4'(xr));
      drive(1'b1, rand256(), rand256(), 8'($urandom), 1'b0, 1'b0, 1'b0, 4'(xr));
    end

    // R5 R10: mixed random traffic with gaps
    for (int n = 0; n < 400; n++)
      drive(1'($urandom), rand256(), rand256(), 8'($urandom), 1'($urandom),
            1'($urandom), ($urandom % 8) == 0, ($urandom % 4) == 0 ? 4'($urandom) : 4'hF);
    idle();
    idle();
    @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R5: watchdog expired, got running exp finished");
      finishRun();
    end
  end

endmodule